// File: doc/BRIEF.md
# Dual-Zone Page-Strided Flash Read Port

This block is the device side of a small parallel flash interface that can only be read. A host drives it with strobe lines: two active-low zone enables, active-low read and write strobes, a command-latch line, an address-latch line and an 8-bit data bus. All strobes are brought into the system clock domain through a synchronizer. Commands and address bytes are taken at the end of each write pulse, that is when the write strobe rises. Read data is produced when the read strobe falls.

Each of the two zones has its own mode, its own address-cycle count, its own byte pointer and its own byte array. A mode command picks one of three read modes. Each mode puts a different offset into the first address byte. The second and third address bytes are multiplied by a 528-byte page stride, so the pointer runs linearly across pages that include their spare area. Every read strobe returns the byte at the pointer and then advances the pointer.

The block never reports itself as busy. Protocol misuse is recorded in a sticky error flag and does not stop the block. The arrays start out erased and can be loaded through a side port by the testbench.

Top module: `nand_rd_if`

## Requirements
- R1: After reset, `dout_oe`, `rdy` and `proto_err` are all 0, and every byte of both arrays reads back as 0xFF until a preload writes it.
- R2: A zone is chosen from `ce0_n`/`ce1_n` at the moment of each strobe event. `ce0_n` low selects zone 0, even when `ce1_n` is also low. `ce1_n` low with `ce0_n` high selects zone 1. With both enables high, every strobe is ignored: no pointer, mode or output changes.
- R3: The command bytes 0x00, 0x01 and 0x50 select read modes 1, 2 and 3, and each one restarts the address-cycle count at zero. Command 0xFF returns the zone to the wait state, in which no mode is active.
- R4: The first address byte after a mode command loads the pointer with that byte. Mode 2 also sets pointer bit 8 (0x100), and mode 3 also sets pointer bit 9 (0x200).
- R5: The second address byte adds byte×528×256 to the pointer, and the third adds byte×528. The array is indexed by the pointer modulo `MEM_BYTES`.
- R6: A falling read strobe with both latch lines low puts the byte at the pointer on `dout`, drives `dout_oe` to 1, and then increments the pointer.
- R7: While a zone is selected and both strobes are high, `dout_oe` goes to 0 and that zone's `rdy` bit goes to 1. A `rdy` bit never falls again until reset.
- R8: Commands and address bytes are latched only on a rising write strobe. If the command-latch line is high, the byte is a command, even when the address-latch line is also high. Otherwise, if the address-latch line is high, the byte is an address.
- R9: `proto_err` becomes 1 and stays 1 until reset on any of these events: an unknown command byte, an address byte in the wait state, a fourth address byte, a write pulse with both latch lines low, or a read strobe with a latch line high. An unknown command or a rejected address byte leaves the zone's state unchanged.
- R10: The two zones keep independent pointers, modes and arrays. Traffic on one zone does not disturb the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce0_n | input | 1 | Zone 0 enable, active low, has priority |
| ce1_n | input | 1 | Zone 1 enable, active low |
| re_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cle | input | 1 | Command-latch line |
| ale | input | 1 | Address-latch line |
| din | input | 8 | Host-driven data bus |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Read data drive enable |
| rdy | output | 2 | Per-zone ready |
| proto_err | output | 1 | Sticky protocol error |
| pre_we | input | 1 | Preload write strobe |
| pre_zone | input | 1 | Preload zone select |
| pre_addr | input | IDX_W | Preload byte index |
| pre_data | input | 8 | Preload byte |

## Verification
The address path is exercised in all three modes. The test cases use first bytes that separate the 0x100 and 0x200 offsets, a third byte that separates the 528 stride, and a second byte whose 135168 step lands exactly on index 0 and so shows the modulo wrap. Further cases restart a mode partway through an address sequence and send a command with both latch lines high; these distinguish a restarted count from a continued one and show that the command-latch line wins. Reads are run on zone 0, on zone 1, with both enables low and with neither enable low, which shows the priority and the independence of the zones. A read in zone 1's unloaded upper half shows the erased value. Each error kind is provoked from a fresh reset, so every one of them is shown to set the flag on its own.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

   typedef enum logic [1:0] {
      MD_WAIT = 2'd0,
      MD_RD1  = 2'd1,
      MD_RD2  = 2'd2,
      MD_RD3  = 2'd3
   } rd_mode_e;

   localparam logic [7:0] OP_RESET = 8'hFF;
   localparam logic [7:0] OP_RD1   = 8'h00;
   localparam logic [7:0] OP_RD2   = 8'h01;
   localparam logic [7:0] OP_RD3   = 8'h50;

   localparam int PAGE_STRIDE  = 528;
   localparam int BLOCK_PAGES  = 256;
   localparam int NUM_ZONES    = 2;

   typedef struct packed {
      logic       ce0_n;
      logic       ce1_n;
      logic       re_n;
      logic       we_n;
      logic       cle;
      logic       ale;
      logic [7:0] d;
   } pin_bus_t;

   localparam int PIN_W = $bits(pin_bus_t);

   function automatic logic [9:0] mode_offset(input rd_mode_e m);
      case (m)
         MD_RD2:  return 10'h100;
         MD_RD3:  return 10'h200;
         default: return 10'h000;
      endcase
   endfunction

endpackage

// File: rtl/nand_rd_sync.sv
module nand_rd_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] rst_val,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= rst_val;
               else        chain[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= rst_val;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign d_out = chain[STAGES-1];

endmodule

// File: rtl/nand_rd_zone.sv
module nand_rd_zone
   import nand_rd_pkg::*;
#(
   parameter int MEM_BYTES = 1024,
   parameter int ADDR_W    = 28,
   localparam int IDX_W    = $clog2(MEM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_ev,
   input  logic              addr_ev,
   input  logic              rd_ev,
   input  logic [7:0]        bus_d,
   input  logic              pre_we,
   input  logic [IDX_W-1:0]  pre_addr,
   input  logic [7:0]        pre_data,
   output logic [7:0]        rd_byte,
   output logic              err
);

   localparam logic [ADDR_W-1:0] STEP_BLOCK = ADDR_W'(PAGE_STRIDE * BLOCK_PAGES);
   localparam logic [ADDR_W-1:0] STEP_PAGE  = ADDR_W'(PAGE_STRIDE);

   rd_mode_e          mode;
   logic [1:0]        acnt;
   logic [ADDR_W-1:0] ptr;
   logic [7:0]        mem [MEM_BYTES];

   logic [ADDR_W-1:0] d_ext;
   logic              cmd_known;
   rd_mode_e          cmd_mode;
   logic              addr_bad;

   assign d_ext = ADDR_W'(bus_d);

   always_comb begin
      cmd_known = 1'b1;
      cmd_mode  = MD_WAIT;
      case (bus_d)
         OP_RESET: cmd_mode = MD_WAIT;
         OP_RD1:   cmd_mode = MD_RD1;
         OP_RD2:   cmd_mode = MD_RD2;
         OP_RD3:   cmd_mode = MD_RD3;
         default:  cmd_known = 1'b0;
      endcase
   end

   assign addr_bad = (mode == MD_WAIT) || (acnt == 2'd3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= MD_WAIT;
         acnt    <= 2'd0;
         ptr     <= '0;
         rd_byte <= 8'h00;
         err     <= 1'b0;
      end else begin
         if (cmd_ev) begin
            if (!cmd_known) begin
               err <= 1'b1;
            end else begin
               mode <= cmd_mode;
               if (cmd_mode != MD_WAIT) acnt <= 2'd0;
            end
         end else if (addr_ev) begin
            if (addr_bad) begin
               err <= 1'b1;
            end else begin
               case (acnt)
                  2'd0:    ptr <= d_ext | ADDR_W'(mode_offset(mode));
                  2'd1:    ptr <= ptr + d_ext * STEP_BLOCK;
                  default: ptr <= ptr + d_ext * STEP_PAGE;
               endcase
               acnt <= acnt + 2'd1;
            end
         end else if (rd_ev) begin
            rd_byte <= mem[ptr[IDX_W-1:0]];
            ptr     <= ptr + ADDR_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
      end else if (pre_we) begin
         mem[pre_addr] <= pre_data;
      end
   end

endmodule

// File: rtl/nand_rd_if.sv
module nand_rd_if
   import nand_rd_pkg::*;
#(
   parameter int MEM_BYTES   = 1024,
   parameter int ADDR_W      = 28,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = $clog2(MEM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce0_n,
   input  logic              ce1_n,
   input  logic              re_n,
   input  logic              we_n,
   input  logic              cle,
   input  logic              ale,
   input  logic [7:0]        din,
   output logic [7:0]        dout,
   output logic              dout_oe,
   output logic [1:0]        rdy,
   output logic              proto_err,
   input  logic              pre_we,
   input  logic              pre_zone,
   input  logic [IDX_W-1:0]  pre_addr,
   input  logic [7:0]        pre_data
);

   localparam longint MAX_PTR = longint'(255) * PAGE_STRIDE * (BLOCK_PAGES + 1) + 1023;

   generate
      if ((1 << IDX_W) != MEM_BYTES) begin : g_bad_depth
         $error("MEM_BYTES must be a power of two");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < IDX_W || ADDR_W > 62 || (longint'(1) << ADDR_W) <= MAX_PTR) begin : g_bad_addr
         $error("ADDR_W too narrow for the largest address");
      end
   endgenerate

   pin_bus_t raw, syn, prv;
   pin_bus_t idle_val;

   assign raw      = '{ce0_n: ce0_n, ce1_n: ce1_n, re_n: re_n, we_n: we_n,
                       cle: cle, ale: ale, d: din};
   assign idle_val = '{ce0_n: 1'b1, ce1_n: 1'b1, re_n: 1'b1, we_n: 1'b1,
                       cle: 1'b0, ale: 1'b0, d: 8'h00};

   nand_rd_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .rst_val(idle_val),
      .d_in   (raw),
      .d_out  (syn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv <= idle_val;
      else        prv <= syn;
   end

   // zone choice: enable 0 wins over enable 1
   logic prv_any, prv_zone, syn_any, syn_zone;
   assign prv_any  = !prv.ce0_n || !prv.ce1_n;
   assign prv_zone = prv.ce0_n;
   assign syn_any  = !syn.ce0_n || !syn.ce1_n;
   assign syn_zone = syn.ce0_n;

   logic we_rise, re_fall;
   logic cmd_ev, addr_ev, rd_ev, idle_ev, bad_ev;
   assign we_rise = syn.we_n && !prv.we_n && prv_any;
   assign re_fall = !syn.re_n && prv.re_n && prv_any;
   assign cmd_ev  = we_rise && prv.cle;
   assign addr_ev = we_rise && !prv.cle && prv.ale;
   assign rd_ev   = re_fall && !prv.cle && !prv.ale;
   assign bad_ev  = (we_rise && !prv.cle && !prv.ale) || (re_fall && (prv.cle || prv.ale));
   assign idle_ev = syn_any && syn.re_n && syn.we_n;

   logic [7:0]           zone_byte [NUM_ZONES];
   logic [NUM_ZONES-1:0] zone_err;

   generate
      for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
         logic hit;
         assign hit = (prv_zone == 1'(z));
         nand_rd_zone #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W)) u_zone (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd_ev  (cmd_ev && hit),
            .addr_ev (addr_ev && hit),
            .rd_ev   (rd_ev && hit),
            .bus_d   (prv.d),
            .pre_we  (pre_we && (pre_zone == 1'(z))),
            .pre_addr(pre_addr),
            .pre_data(pre_data),
            .rd_byte (zone_byte[z]),
            .err     (zone_err[z])
         );
      end
   endgenerate

   logic last_zone, strobe_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_oe    <= 1'b0;
         rdy        <= '0;
         last_zone  <= 1'b0;
         strobe_err <= 1'b0;
      end else begin
         if (bad_ev) strobe_err <= 1'b1;
         if (rd_ev) begin
            dout_oe   <= 1'b1;
            last_zone <= prv_zone;
         end else if (idle_ev) begin
            dout_oe <= 1'b0;
         end
         if (idle_ev) rdy[syn_zone] <= 1'b1;
      end
   end

   assign dout      = zone_byte[last_zone];
   assign proto_err = strobe_err || (|zone_err);

endmodule

// File: rtl/nand_rd_chk.sv
module nand_rd_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       dout_oe,
   input logic [1:0] rdy,
   input logic       proto_err,
   input logic       ev_cmd,
   input logic       ev_addr,
   input logic       ev_rd,
   input logic       ev_idle
);

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err); // R9

   AST_RDY0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(rdy[0])); // R7

   AST_RDY1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(rdy[1])); // R7

   AST_OE_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_oe) |-> $past(ev_rd)); // R6

   AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_idle |=> !dout_oe); // R7

   AST_ONE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_cmd, ev_addr, ev_rd})); // R8

endmodule

bind nand_rd_if nand_rd_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dout_oe  (dout_oe),
   .rdy      (rdy),
   .proto_err(proto_err),
   .ev_cmd   (cmd_ev),
   .ev_addr  (addr_ev),
   .ev_rd    (rd_ev),
   .ev_idle  (idle_ev)
);

// File: tb/sim_nand_rd_if.sv
`timescale 1ns/1ps
module sim_nand_rd_if;

   localparam int MEMB = 1024;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce0_n = 1'b1, ce1_n = 1'b1, re_n = 1'b1, we_n = 1'b1;
   logic       cle = 1'b0, ale = 1'b0;
   logic [7:0] din = 8'h00;
   logic [7:0] dout;
   logic       dout_oe;
   logic [1:0] rdy;
   logic       proto_err;
   logic       pre_we = 1'b0, pre_zone = 1'b0;
   logic [9:0] pre_addr = '0;
   logic [7:0] pre_data = '0;

   always #10 clk = ~clk;

   nand_rd_if u0 (
      .clk(clk), .rst_n(rst_n), .ce0_n(ce0_n), .ce1_n(ce1_n), .re_n(re_n), .we_n(we_n),
      .cle(cle), .ale(ale), .din(din), .dout(dout), .dout_oe(dout_oe), .rdy(rdy),
      .proto_err(proto_err), .pre_we(pre_we), .pre_zone(pre_zone), .pre_addr(pre_addr),
      .pre_data(pre_data)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   // reference model
   int  m_mem [2][MEMB];
   int  m_mode [2];
   int  m_cnt  [2];
   longint m_ptr [2];
   bit  m_err, m_oe;
   bit  [1:0] m_rdy;
   int  m_dout;
   int  m_zone = -1;
   bit  settled = 0;

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #5;
      if (settled && rst_n && !finished) begin
         check("R9 proto_err", int'(proto_err), int'(m_err));
         check("R7 rdy", int'(rdy), int'(m_rdy));
         check("R6 dout_oe", int'(dout_oe), int'(m_oe));
         if (m_oe) check("R6 dout", int'(dout), m_dout);
      end
   end

   function automatic int zone_of(bit c0, bit c1);
      if (!c0) return 0;
      if (!c1) return 1;
      return -1;
   endfunction

   task automatic do_reset();
      settled = 0;
      @(negedge clk);
      rst_n = 1'b0; ce0_n = 1; ce1_n = 1; re_n = 1; we_n = 1; cle = 0; ale = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int z = 0; z < 2; z++) begin
         for (int i = 0; i < MEMB; i++) m_mem[z][i] = 255;
         m_mode[z] = 0; m_cnt[z] = 0; m_ptr[z] = 0;
      end
      m_err = 0; m_oe = 0; m_rdy = 0; m_zone = -1;
      repeat (2) @(negedge clk);
      settled = 1;
   endtask

   task automatic preload();
      for (int i = 0; i < MEMB; i++) begin
         @(negedge clk);
         pre_we = 1; pre_zone = 0; pre_addr = 10'(i); pre_data = 8'((i * 37 + 11) & 255);
         m_mem[0][i] = (i * 37 + 11) & 255;
      end
      for (int i = 0; i < MEMB / 2; i++) begin
         @(negedge clk);
         pre_we = 1; pre_zone = 1; pre_addr = 10'(i); pre_data = 8'((i * 91 + 200) & 255);
         m_mem[1][i] = (i * 91 + 200) & 255;
      end
      @(negedge clk);
      pre_we = 0;
   endtask

   task automatic select(bit c0, bit c1);
      settled = 0;
      @(negedge clk);
      ce0_n = c0; ce1_n = c1;
      repeat (6) @(negedge clk);
      m_zone = zone_of(c0, c1);
      if (m_zone >= 0) begin
         m_rdy[m_zone] = 1; m_oe = 0;
      end
      settled = 1;
   endtask

   task automatic write_byte(bit l_cmd, bit l_adr, logic [7:0] d);
      int z;
      settled = 0;
      @(negedge clk);
      cle = l_cmd; ale = l_adr; din = d;
      repeat (2) @(negedge clk);
      we_n = 0;
      repeat (5) @(negedge clk);
      we_n = 1;
      repeat (5) @(negedge clk);
      cle = 0; ale = 0;
      z = m_zone;
      if (z >= 0) begin
         if (l_cmd) begin
            case (d)
               8'hFF: m_mode[z] = 0;
               8'h00: begin m_mode[z] = 1; m_cnt[z] = 0; end
               8'h01: begin m_mode[z] = 2; m_cnt[z] = 0; end
               8'h50: begin m_mode[z] = 3; m_cnt[z] = 0; end
               default: m_err = 1;
            endcase
         end else if (l_adr) begin
            if (m_mode[z] == 0 || m_cnt[z] == 3) m_err = 1;
            else begin
               case (m_cnt[z])
                  0: m_ptr[z] = longint'(d) | (m_mode[z] == 2 ? 256 : m_mode[z] == 3 ? 512 : 0);
                  1: m_ptr[z] = m_ptr[z] + longint'(d) * 528 * 256;
                  default: m_ptr[z] = m_ptr[z] + longint'(d) * 528;
               endcase
               m_cnt[z]++;
            end
         end else m_err = 1;
         m_oe = 0;
      end
      repeat (2) @(negedge clk);
      settled = 1;
   endtask

   task automatic cmd(logic [7:0] c);
      write_byte(1, 0, c);
   endtask

   task automatic addr3(int mode_cmd, logic [7:0] a0, logic [7:0] a1, logic [7:0] a2);
      cmd(8'(mode_cmd));
      write_byte(0, 1, a0);
      write_byte(0, 1, a1);
      write_byte(0, 1, a2);
   endtask

   // read strobe; latch_hi puts the command-latch line high (misuse)
   task automatic read_byte(string req, bit latch_hi);
      int z;
      settled = 0;
      @(negedge clk);
      cle = latch_hi;
      repeat (2) @(negedge clk);
      re_n = 0;
      repeat (6) @(negedge clk);
      z = m_zone;
      if (z >= 0) begin
         if (latch_hi) m_err = 1;
         else begin
            m_dout = m_mem[z][int'(m_ptr[z] % MEMB)];
            m_ptr[z]++;
            m_oe = 1;
            check(req, int'(dout), m_dout);
         end
      end
      settled = 1;
      @(negedge clk);
      settled = 0;
      re_n = 1;
      repeat (6) @(negedge clk);
      cle = 0;
      if (z >= 0) m_oe = 0;
      repeat (2) @(negedge clk);
      settled = 1;
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: reset values and erased contents
      check("R1 dout_oe", int'(dout_oe), 0);
      check("R1 rdy", int'(rdy), 0);
      check("R1 proto_err", int'(proto_err), 0);
      select(0, 1);
      check("R7 rdy after select", int'(rdy), 1);
      addr3(8'h00, 8'h03, 0, 0);
      read_byte("R1 erased byte", 0);
      preload();

      // R4 mode 1 offset, R6 streaming
      addr3(8'h00, 8'h05, 0, 0);
      for (int k = 0; k < 3; k++) read_byte("R6 mode1 stream", 0);
      // R4 mode 2 sets 0x100
      addr3(8'h01, 8'h10, 0, 0);
      read_byte("R4 mode2 offset", 0);
      read_byte("R4 mode2 next", 0);
      // R4 mode 3 + R5 page stride
      addr3(8'h50, 8'h03, 0, 1);
      read_byte("R5 page stride mode3", 0);
      // R5 block step wraps to index 0
      addr3(8'h00, 8'h00, 1, 0);
      read_byte("R5 block step modulo", 0);
      addr3(8'h01, 8'hFF, 3, 2);
      read_byte("R5 mixed address", 0);
      // R3 restart of address count
      cmd(8'h00);
      write_byte(0, 1, 8'h01);
      cmd(8'h01);
      write_byte(0, 1, 8'h02);
      write_byte(0, 1, 8'h00);
      write_byte(0, 1, 8'h00);
      read_byte("R3 restarted count", 0);
      // R8 command wins when both latch lines high (0x50 -> mode 3)
      write_byte(1, 1, 8'h50);
      write_byte(0, 1, 8'h07);
      write_byte(0, 1, 8'h00);
      write_byte(0, 1, 8'h00);
      read_byte("R8 cle priority", 0);
      // R10 zone 1 own pointer and array
      select(1, 0);
      check("R7 both ready", int'(rdy), 3);
      addr3(8'h00, 8'h20, 0, 0);
      read_byte("R10 zone1 data", 0);
      addr3(8'h50, 8'h10, 0, 0);
      read_byte("R1 zone1 erased upper", 0);
      // R10 zone 0 pointer kept
      select(0, 1);
      read_byte("R10 zone0 resumes", 0);
      // R2 both enables low -> zone 0
      select(0, 0);
      read_byte("R2 priority zone0", 0);
      // R2 neither selected -> ignored
      select(1, 1);
      read_byte("R2 ignored read", 0);
      write_byte(1, 0, 8'h01);
      select(0, 1);
      read_byte("R2 pointer untouched", 0);
      check("R9 no error so far", int'(proto_err), 0);

      // R9 unknown command
      do_reset(); select(0, 1);
      cmd(8'h00);
      cmd(8'h90);
      check("R9 unknown cmd", int'(proto_err), 1);
      write_byte(0, 1, 8'h04); write_byte(0, 1, 0); write_byte(0, 1, 0);
      read_byte("R9 state kept after bad cmd", 0);
      // R9 / R3 address in wait after 0xFF
      do_reset(); select(0, 1);
      cmd(8'h00);
      cmd(8'hFF);
      check("R3 reset cmd no err", int'(proto_err), 0);
      write_byte(0, 1, 8'h01);
      check("R9 addr in wait", int'(proto_err), 1);
      // R9 fourth address byte
      do_reset(); select(1, 0);
      addr3(8'h00, 1, 0, 0);
      check("R9 three bytes ok", int'(proto_err), 0);
      write_byte(0, 1, 8'h09);
      check("R9 fourth byte", int'(proto_err), 1);
      read_byte("R9 pointer kept after 4th", 0);
      // R9 write pulse with no latch line
      do_reset(); select(0, 1);
      write_byte(0, 0, 8'h12);
      check("R9 bare write", int'(proto_err), 1);
      // R9 read strobe with latch line high
      do_reset(); select(0, 1);
      read_byte("R9 read with cle", 1);
      check("R9 read with cle", int'(proto_err), 1);
      check("R9 no drive on bad read", int'(dout_oe), 0);

      repeat (4) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule